// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a segment register identifier plus an effective address into a linear address. Each of the six segment registers presents its cached base, limit and null flag to the unit. The unit adds the base to the effective address, checks the access against the limit and the null flag, and returns either a linear address or a general-protection fault. The fault check and the result always come out together, one registered cycle after the request.

The processor mode changes how the unit behaves. In legacy/compatibility mode every segment is checked against its limit and the address is computed in 32 bits. The result can never leave the lowest 4 GB. A segment can be one byte long (limit 0) or span the full 4 GB (limit 0xFFFF_FFFF). In 64-bit mode limits and null flags do not apply. Only the two thread-data segments add their base; all other segments act as if their base were zero.

Top module: `segXlate`

## Requirements
- R1: In legacy mode a granted request yields linAddr = {32'b0, (base[31:0] + effAddr[31:0]) mod 2^32}. The upper 32 bits are always zero.
- R2: In legacy mode, effAddr[31:0] greater than the segment's 32-bit limit faults. effAddr[31:0] equal to the limit is granted, so a limit of 0 allows exactly offset 0.
- R3: In legacy mode, a request through a register whose null flag is set faults, whatever its offset.
- R4: In 64-bit mode, segments ES, CS, SS and DS (ids 0, 1, 2, 3) give linAddr = effAddr, whatever their base.
- R5: In 64-bit mode, segments FS (id 4) and GS (id 5) give linAddr = (effAddr + base) mod 2^64, using the full 64-bit base.
- R6: In 64-bit mode, neither the limit nor the null flag causes a fault for ids 0 to 5.
- R7: With every base 0 and every limit 0xFFFF_FFFF, a legacy request gives linAddr = {32'b0, effAddr[31:0]} unchanged.
- R8: A request accepted at one clock edge shows its addrValid or gpFault after the next edge. A cycle without reqValid leaves both outputs low after the following edge.
- R9: addrValid and gpFault are never high together, and linAddr is zero whenever addrValid is low.
- R10: Segment ids 6 and 7 fault in both modes.
- R11: While rstN is low, addrValid, gpFault and linAddr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request this cycle |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility |
| reqSeg | input | 3 | Segment id: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| effAddr | input | 64 | Effective address |
| segBaseFlat | input | 384 | Cached bases, segment i at bits [64*i +: 64] |
| segLimitFlat | input | 192 | Cached limits, segment i at bits [32*i +: 32] |
| segNull | input | 6 | Null-selector flag per segment, bit i for segment i |
| linAddr | output | 64 | Linear address, zero unless addrValid |
| addrValid | output | 1 | Result is a granted translation |
| gpFault | output | 1 | General-protection fault for the request |

## Verification
A wrong internal state shows at the ports on the cycle right after the request. Two cases are possible: a wrong select or mode strobe, and a missing datapath load. A wrong select or mode strobe either sends the wrong base to the adder or lets a null or over-limit access through. A missing datapath load leaves linAddr zero while addrValid is high. Since nothing is stored across requests, each fault in the logic can be seen on a single request, and the bench compares every request against a value it computes itself. The sweep covers every segment id, both modes, both null states and offsets on each side of each limit.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEG_ID_W = 3;

  typedef enum logic [SEG_ID_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } segId_e;

  typedef struct packed {
    logic load;      // capture the sum into the result register
    logic zeroBase;  // treat the selected base as zero
    logic wrap32;    // 32-bit arithmetic, upper half cleared
  } segxCtl_t;
endpackage

// File: rtl/segx_dp.sv
module segx_dp
  import segx_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LEG_W   = 32,
  parameter int NUM_SEG = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SEG_ID_W-1:0]       segId,
  input  logic [ADDR_W-1:0]         effAddr,
  input  logic [NUM_SEG*ADDR_W-1:0] segBaseFlat,
  input  logic [NUM_SEG*LEG_W-1:0]  segLimitFlat,
  input  logic [NUM_SEG-1:0]        segNull,
  input  segxCtl_t                  ctl,
  output logic                      selNull,
  output logic                      overLimit,
  output logic [ADDR_W-1:0]         linAddr
);
  localparam int IDX_W = $clog2(NUM_SEG);

  logic [ADDR_W-1:0] baseArr  [NUM_SEG];
  logic [LEG_W-1:0]  limitArr [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_unpack
    assign baseArr[i]  = segBaseFlat[i*ADDR_W +: ADDR_W];
    assign limitArr[i] = segLimitFlat[i*LEG_W +: LEG_W];
  end

  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] selBase;
  logic [LEG_W-1:0]  selLimit;
  logic [LEG_W-1:0]  legSum;
  logic [ADDR_W-1:0] wideSum;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    if (segId < SEG_ID_W'(NUM_SEG)) selIdx = IDX_W'(segId);
    else                            selIdx = '0;
  end

  assign selBase   = ctl.zeroBase ? '0 : baseArr[selIdx];
  assign selLimit  = limitArr[selIdx];
  assign selNull   = segNull[selIdx];
  assign overLimit = effAddr[LEG_W-1:0] > selLimit;

  assign legSum  = selBase[LEG_W-1:0] + effAddr[LEG_W-1:0];
  assign wideSum = selBase + effAddr;

  always_comb begin
    if (ctl.wrap32) nextAddr = {{(ADDR_W-LEG_W){1'b0}}, legSum};
    else            nextAddr = wideSum;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         linAddr <= '0;
    else if (ctl.load) linAddr <= nextAddr;
    else               linAddr <= '0;
  end
endmodule

// File: rtl/segx_ctrl.sv
module segx_ctrl
  import segx_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                mode64,
  input  logic [SEG_ID_W-1:0] segId,
  input  logic                selNull,
  input  logic                overLimit,
  output segxCtl_t            ctl,
  output logic                addrValid,
  output logic                gpFault
);
  logic idOk;
  logic isThreadSeg;
  logic faultNow;

  assign idOk        = segId < SEG_ID_W'(NUM_SEG);
  assign isThreadSeg = (segId == SEG_FS) || (segId == SEG_GS);
  assign faultNow    = reqValid && (!idOk || (!mode64 && (selNull || overLimit)));

  always_comb begin
    ctl.load     = reqValid && !faultNow;
    ctl.zeroBase = mode64 && !isThreadSeg;
    ctl.wrap32   = !mode64;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid <= 1'b0;
      gpFault   <= 1'b0;
    end else begin
      addrValid <= ctl.load;
      gpFault   <= faultNow;
    end
  end

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(addrValid && gpFault));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (addrValid || gpFault));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!addrValid && !gpFault));

  assert_bad_id_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && segId >= SEG_ID_W'(NUM_SEG)) |=> gpFault);
endmodule

// File: rtl/segXlate.sv
module segXlate
  import segx_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LEG_W   = 32,
  parameter int NUM_SEG = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      mode64,
  input  logic [SEG_ID_W-1:0]       reqSeg,
  input  logic [ADDR_W-1:0]         effAddr,
  input  logic [NUM_SEG*ADDR_W-1:0] segBaseFlat,
  input  logic [NUM_SEG*LEG_W-1:0]  segLimitFlat,
  input  logic [NUM_SEG-1:0]        segNull,
  output logic [ADDR_W-1:0]         linAddr,
  output logic                      addrValid,
  output logic                      gpFault
);
  segxCtl_t ctl;
  logic     selNull;
  logic     overLimit;

  segx_ctrl #(.NUM_SEG(NUM_SEG)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode64(mode64),
    .segId(reqSeg), .selNull(selNull), .overLimit(overLimit),
    .ctl(ctl), .addrValid(addrValid), .gpFault(gpFault)
  );

  segx_dp #(.ADDR_W(ADDR_W), .LEG_W(LEG_W), .NUM_SEG(NUM_SEG)) u_dp (
    .clk(clk), .rstN(rstN), .segId(reqSeg), .effAddr(effAddr),
    .segBaseFlat(segBaseFlat), .segLimitFlat(segLimitFlat), .segNull(segNull),
    .ctl(ctl), .selNull(selNull), .overLimit(overLimit), .linAddr(linAddr)
  );

  assert_null_faults_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mode64 && selNull) |=> gpFault);

  assert_upper_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !mode64) |=> (linAddr[ADDR_W-1:LEG_W] == '0));

  assert_addr_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> (linAddr == '0));
endmodule

// File: tb/segXlate_tb.sv
module segXlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              mode64 = 1'b0;
  logic [2:0]        reqSeg = '0;
  logic [63:0]       effAddr = '0;
  logic [NSEG*64-1:0] segBaseFlat = '0;
  logic [NSEG*32-1:0] segLimitFlat = '0;
  logic [NSEG-1:0]   segNull = '0;
  logic [63:0]       linAddr;
  logic              addrValid;
  logic              gpFault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segXlate u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .mode64(mode64),
    .reqSeg(reqSeg), .effAddr(effAddr), .segBaseFlat(segBaseFlat),
    .segLimitFlat(segLimitFlat), .segNull(segNull),
    .linAddr(linAddr), .addrValid(addrValid), .gpFault(gpFault)
  );

  function automatic logic [63:0] baseOf(int s);
    return segBaseFlat[s*64 +: 64];
  endfunction

  function automatic logic [31:0] limitOf(int s);
    return segLimitFlat[s*32 +: 32];
  endfunction

  task automatic check(string req, logic [63:0] expAddr, logic expOk, logic expFlt);
    total++;
    if (linAddr !== expAddr || addrValid !== expOk || gpFault !== expFlt) begin
      bad++;
      $display("FAIL %s: seg=%0d m64=%0b ea=%h got addr=%h ok=%0b flt=%0b exp addr=%h ok=%0b flt=%0b",
               req, reqSeg, mode64, effAddr, linAddr, addrValid, gpFault, expAddr, expOk, expFlt);
    end
  endtask

  // issue one request, compute the expectation from the requirements, check one cycle later
  task automatic run(logic m, int s, logic [63:0] ea, string req);
    logic [63:0] ex;
    logic flt;
    mode64 = m; reqSeg = 3'(s); effAddr = ea; reqValid = 1'b1;
    ex = '0; flt = 1'b0;
    if (s >= NSEG) flt = 1'b1;                                  // R10
    else if (!m) begin
      if (segNull[s]) flt = 1'b1;                               // R3
      else if (ea[31:0] > limitOf(s)) flt = 1'b1;               // R2
      else ex = {32'b0, baseOf(s)[31:0] + ea[31:0]};            // R1
    end else if (s == 4 || s == 5) ex = ea + baseOf(s);         // R5
    else ex = ea;                                               // R4
    @(posedge clk); #1;
    check(req, ex, !flt, flt);
    reqValid = 1'b0;
  endtask

  initial begin
    logic [63:0] eaList [6];
    segBaseFlat  = {64'h8000_0000_0000_1000, 64'hFFFF_FFFF_0000_0010,
                    64'h0000_0000_2000_0000, 64'h1234_5678_FFFF_F000,
                    64'h0000_0000_0000_0000, 64'h0000_0000_0000_0100};
    segLimitFlat = {32'h0001_2345, 32'h0000_FFFF, 32'h0000_7FFF,
                    32'h0000_1000, 32'hFFFF_FFFF, 32'h0000_0000};
    repeat (3) @(posedge clk);
    #1;
    check("R11", 64'h0, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int m = 0; m < 2; m++) begin
      for (int nm = 0; nm < 2; nm++) begin
        segNull = nm ? 6'h3F : 6'h00;
        for (int s = 0; s < 8; s++) begin
          logic [31:0] lim;
          lim = (s < NSEG) ? limitOf(s) : 32'h0;
          eaList[0] = 64'h0;
          eaList[1] = {32'h0, lim};
          eaList[2] = {32'h0, lim + 32'h1};
          eaList[3] = {32'h0, lim >> 1};
          eaList[4] = 64'hFFFF_FFFF_FFFF_FFFF;
          eaList[5] = 64'h0000_1234_0000_0010;
          for (int k = 0; k < 6; k++) begin
            string tag;
            if (s >= NSEG) tag = "R10";
            else if (m == 0 && nm == 1) tag = "R3";
            else if (m == 0) tag = (k == 1 || k == 2) ? "R2" : "R1";
            else if (nm == 1 || k == 2) tag = "R6";
            else tag = (s >= 4) ? "R5" : "R4";
            run(logic'(m), s, eaList[k], tag);
          end
        end
      end
    end

    // R8 idle cycle after a request: both outputs low, address zero (R9)
    segNull = '0;
    run(1'b0, 1, 64'h10, "R8");
    @(posedge clk); #1;
    check("R8", 64'h0, 1'b0, 1'b0);

    // R7 flat configuration
    segBaseFlat  = '0;
    segLimitFlat = {NSEG{32'hFFFF_FFFF}};
    for (int s = 0; s < NSEG; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] ea;
        ea = {32'hA5A5_0000 + 32'(k), 32'h0F0F_0000 * 32'(k + 1) + 32'(s)};
        run(1'b0, s, ea, "R7");
      end
    end

    // R11 reset asserted again clears outputs
    reqValid = 1'b1; mode64 = 1'b0; reqSeg = 3'd1; effAddr = 64'h44;
    @(posedge clk); #1;
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R11", 64'h0, 1'b0, 1'b0);
    reqValid = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule